// File: doc/BRIEF.md
# Transfer Start Gate

This block decides the cycle in which a queued bus transfer may begin. A command decoder presents one descriptor at a time: direction, whether it runs in the high data rate double data rate mode, and a terminate-on-completion flag. For a transfer that opens the bus with a START, the gate holds the descriptor back until the FIFO side is ready. A write needs enough data already in the transmit FIFO. A read needs enough free space in the receive FIFO. The gate then pulses a start strobe together with the kind of condition the bus sequencer must produce.

When a transfer finishes without terminate-on-completion, the bus stays owned and the next transfer follows with a RESTART. A plain-rate RESTART goes ahead without any threshold check. A double-data-rate RESTART whose threshold is not met cannot stall the bus. In that case the gate asks the sequencer for an HDR-EXIT and then a STOP, waits for each to be acknowledged, and later begins the same transfer with a fresh START once the FIFO is ready.

Both thresholds sit in a small register that software writes. A threshold of zero lets a transfer start immediately. The gate does not generate any bus pattern itself.

Top module: `xfer_start_gate`

## Requirements
- R1: While reset is asserted and just after it is released, start_pulse, exit_req and stop_req are 0, next_is_restart is 0, and both thresholds are 0.
- R2: From the free-bus state, a write (cmd_rnw=0) starts with start_pulse=1 and start_kind=0 (START) only in a cycle where tx_level >= the transmit threshold. Until then no output pulses.
- R3: From the free-bus state, a read (cmd_rnw=1) starts with a START only in a cycle where rx_free >= the receive threshold. Until then no output pulses.
- R4: With a threshold of 0, a valid command on a free bus produces start_pulse in the same cycle that cmd_valid is first seen, whatever the FIFO level.
- R5: A cycle with thr_we=1 loads both thresholds at the next rising edge. Any later comparison uses the new values.
- R6: After xfer_done for a transfer whose terminate-on-completion flag was 0, next_is_restart is 1 from the next cycle on. The next start then carries start_kind=1 (RESTART).
- R7: A plain-rate (cmd_hdr=0) transfer following by RESTART starts in its first valid cycle, whatever the FIFO levels.
- R8: A double-data-rate transfer following by RESTART starts with start_kind=1 if its threshold is met. If the threshold is not met, the gate raises exit_req for one cycle, waits for seq_ack, then raises stop_req for one cycle, waits for seq_ack, and then waits to begin that same transfer with a START.
- R9: After xfer_done for a transfer with terminate-on-completion 1, a double-data-rate transfer is closed by exit_req then stop_req, and a plain-rate one by stop_req alone. Each request waits for its seq_ack, and the next start is a START.
- R10: exit_req and stop_req are single-cycle pulses. No start_pulse is issued from the first exit or stop request until the final seq_ack returns the bus to the free state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| thr_we | input | 1 | Load both start thresholds |
| thr_tx_wdata | input | LW | New transmit start threshold (entries) |
| thr_rx_wdata | input | LW | New receive start threshold (free entries) |
| tx_level | input | LW | Entries held in the transmit FIFO |
| rx_free | input | LW | Free entries in the receive FIFO |
| cmd_valid | input | 1 | Descriptor pending; held until start_pulse |
| cmd_rnw | input | 1 | 1 = read, 0 = write |
| cmd_hdr | input | 1 | 1 = double-data-rate mode transfer |
| cmd_toc | input | 1 | Terminate on completion |
| xfer_done | input | 1 | Sequencer finished the running transfer |
| seq_ack | input | 1 | Sequencer completed the requested exit or stop |
| start_pulse | output | 1 | Begin the pending transfer; consumes the descriptor |
| start_kind | output | 1 | 0 = START, 1 = RESTART (valid with start_pulse) |
| exit_req | output | 1 | One-cycle HDR-EXIT request |
| stop_req | output | 1 | One-cycle STOP request |
| next_is_restart | output | 1 | Bus held; the next transfer would begin with RESTART |

## Verification
The bench builds the gate with an 8-entry FIFO depth, so levels and thresholds are 4 bits wide. This keeps both the zero threshold and the full-depth threshold of 8 within a few cycles of stimulus, so the boundary cases one below and exactly at a threshold are reached directly. That depth also makes it cheap to hold a double-data-rate RESTART below its threshold for several cycles while exit and stop acknowledgements are delayed. The same sequence then tests that the fallback waits for each acknowledgement and later resumes with a START.

// File: rtl/xsg_pkg.sv
package xsg_pkg;

  typedef enum logic [2:0] {
    GS_IDLE      = 3'd0,
    GS_BUSY      = 3'd1,
    GS_CHAIN     = 3'd2,
    GS_EXIT_ISS  = 3'd3,
    GS_EXIT_WAIT = 3'd4,
    GS_STOP_ISS  = 3'd5,
    GS_STOP_WAIT = 3'd6
  } gate_st_e;

  typedef enum logic {
    COND_START   = 1'b0,
    COND_RESTART = 1'b1
  } cond_e;

  // Attributes of the running transfer kept while it is on the bus
  typedef struct packed {
    logic hdr;
    logic toc;
  } run_attr_t;

endpackage

// File: rtl/xsg_thr_regs.sv
module xsg_thr_regs #(
  parameter int LW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [LW-1:0] tx_wdata,
  input  logic [LW-1:0] rx_wdata,
  output logic [LW-1:0] tx_thr,
  output logic [LW-1:0] rx_thr
);

  logic [LW-1:0] tx_d, rx_d;

  always_comb begin
    tx_d = tx_thr;
    rx_d = rx_thr;
    if (we) begin
      tx_d = tx_wdata;
      rx_d = rx_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_thr <= '0;
      rx_thr <= '0;
    end else begin
      tx_thr <= tx_d;
      rx_thr <= rx_d;
    end
  end

endmodule

// File: rtl/xsg_thr_cmp.sv
module xsg_thr_cmp #(
  parameter int LW = 6
) (
  input  logic          rnw,
  input  logic [LW-1:0] tx_level,
  input  logic [LW-1:0] rx_free,
  input  logic [LW-1:0] tx_thr,
  input  logic [LW-1:0] rx_thr,
  output logic          met
);

  logic tx_ok, rx_ok;

  // A zero threshold compares as always satisfied
  assign tx_ok = (tx_level >= tx_thr);
  assign rx_ok = (rx_free  >= rx_thr);
  assign met   = rnw ? rx_ok : tx_ok;

endmodule

// File: rtl/xsg_fsm.sv
module xsg_fsm
  import xsg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_valid,
  input  logic cmd_hdr,
  input  logic cmd_toc,
  input  logic thr_met,
  input  logic xfer_done,
  input  logic seq_ack,
  output logic start_pulse,
  output logic start_kind,
  output logic exit_req,
  output logic stop_req,
  output logic next_is_restart
);

  gate_st_e  st_q, st_d;
  run_attr_t cur_q, cur_d;
  cond_e     kind;
  logic      cur_en;

  always_comb begin
    st_d        = st_q;
    cur_d       = cur_q;
    cur_en      = 1'b0;
    start_pulse = 1'b0;
    kind        = COND_START;
    unique case (st_q)
      GS_IDLE: begin
        if (cmd_valid && thr_met) begin
          start_pulse = 1'b1;
          kind        = COND_START;
          cur_en      = 1'b1;
          st_d        = GS_BUSY;
        end
      end
      GS_BUSY: begin
        if (xfer_done) begin
          if (cur_q.toc) st_d = cur_q.hdr ? GS_EXIT_ISS : GS_STOP_ISS;
          else           st_d = GS_CHAIN;
        end
      end
      GS_CHAIN: begin
        if (cmd_valid) begin
          if (!cmd_hdr || thr_met) begin
            start_pulse = 1'b1;
            kind        = COND_RESTART;
            cur_en      = 1'b1;
            st_d        = GS_BUSY;
          end else begin
            st_d = GS_EXIT_ISS;
          end
        end
      end
      GS_EXIT_ISS:  st_d = GS_EXIT_WAIT;
      GS_EXIT_WAIT: if (seq_ack) st_d = GS_STOP_ISS;
      GS_STOP_ISS:  st_d = GS_STOP_WAIT;
      GS_STOP_WAIT: if (seq_ack) st_d = GS_IDLE;
      default:      st_d = GS_IDLE;
    endcase
    if (cur_en) begin
      cur_d.hdr = cmd_hdr;
      cur_d.toc = cmd_toc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= GS_IDLE;
      cur_q <= '0;
    end else begin
      st_q <= st_d;
      if (cur_en) cur_q <= cur_d;
    end
  end

  assign start_kind      = kind;
  assign exit_req        = (st_q == GS_EXIT_ISS);
  assign stop_req        = (st_q == GS_STOP_ISS);
  assign next_is_restart = (st_q == GS_CHAIN);

endmodule

// File: rtl/xfer_start_gate.sv
module xfer_start_gate #(
  parameter int FIFO_DEPTH = 32,
  localparam int LW = $clog2(FIFO_DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          thr_we,
  input  logic [LW-1:0] thr_tx_wdata,
  input  logic [LW-1:0] thr_rx_wdata,
  input  logic [LW-1:0] tx_level,
  input  logic [LW-1:0] rx_free,
  input  logic          cmd_valid,
  input  logic          cmd_rnw,
  input  logic          cmd_hdr,
  input  logic          cmd_toc,
  input  logic          xfer_done,
  input  logic          seq_ack,
  output logic          start_pulse,
  output logic          start_kind,
  output logic          exit_req,
  output logic          stop_req,
  output logic          next_is_restart
);

  logic [LW-1:0] tx_thr, rx_thr;
  logic          thr_met;

  xsg_thr_regs #(.LW(LW)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (thr_we),
    .tx_wdata (thr_tx_wdata),
    .rx_wdata (thr_rx_wdata),
    .tx_thr   (tx_thr),
    .rx_thr   (rx_thr)
  );

  xsg_thr_cmp #(.LW(LW)) u_cmp (
    .rnw      (cmd_rnw),
    .tx_level (tx_level),
    .rx_free  (rx_free),
    .tx_thr   (tx_thr),
    .rx_thr   (rx_thr),
    .met      (thr_met)
  );

  xsg_fsm u_fsm (
    .clk             (clk),
    .rst_n           (rst_n),
    .cmd_valid       (cmd_valid),
    .cmd_hdr         (cmd_hdr),
    .cmd_toc         (cmd_toc),
    .thr_met         (thr_met),
    .xfer_done       (xfer_done),
    .seq_ack         (seq_ack),
    .start_pulse     (start_pulse),
    .start_kind      (start_kind),
    .exit_req        (exit_req),
    .stop_req        (stop_req),
    .next_is_restart (next_is_restart)
  );

endmodule

// File: rtl/xsg_chk.sv
module xsg_chk #(
  parameter int LW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_rnw,
  input logic          cmd_hdr,
  input logic [LW-1:0] tx_level,
  input logic [LW-1:0] rx_free,
  input logic [LW-1:0] tx_thr,
  input logic [LW-1:0] rx_thr,
  input logic          start_pulse,
  input logic          start_kind,
  input logic          exit_req,
  input logic          stop_req,
  input logic          next_is_restart
);

  AST_WR_START_THR: assert property (@(posedge clk) disable iff (!rst_n)
    (start_pulse && !start_kind && !cmd_rnw) |-> (tx_level >= tx_thr)); // R2
  AST_RD_START_THR: assert property (@(posedge clk) disable iff (!rst_n)
    (start_pulse && !start_kind && cmd_rnw) |-> (rx_free >= rx_thr)); // R3
  AST_RESTART_NEEDS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (start_pulse && start_kind) |-> next_is_restart); // R6
  AST_START_NEEDS_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    (start_pulse && !start_kind) |-> !next_is_restart); // R6
  AST_HDR_RESTART_THR: assert property (@(posedge clk) disable iff (!rst_n)
    (start_pulse && start_kind && cmd_hdr) |->
      (cmd_rnw ? (rx_free >= rx_thr) : (tx_level >= tx_thr))); // R8
  AST_EXIT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    exit_req |=> !exit_req); // R10
  AST_STOP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    stop_req |=> !stop_req); // R10
  AST_NO_START_IN_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
    (exit_req || stop_req) |-> (!start_pulse && !next_is_restart)); // R10

endmodule

bind xfer_start_gate xsg_chk #(.LW(LW)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .cmd_rnw         (cmd_rnw),
  .cmd_hdr         (cmd_hdr),
  .tx_level        (tx_level),
  .rx_free         (rx_free),
  .tx_thr          (tx_thr),
  .rx_thr          (rx_thr),
  .start_pulse     (start_pulse),
  .start_kind      (start_kind),
  .exit_req        (exit_req),
  .stop_req        (stop_req),
  .next_is_restart (next_is_restart)
);

// File: tb/sim_xfer_start_gate.sv
`timescale 1ns/100ps
module sim_xfer_start_gate;

  localparam int DEPTH = 8;
  localparam int W = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic thr_we = 1'b0;
  logic [W-1:0] thr_tx_wdata = '0, thr_rx_wdata = '0;
  logic [W-1:0] tx_level = '0, rx_free = '0;
  logic cmd_valid = 1'b0, cmd_rnw = 1'b0, cmd_hdr = 1'b0, cmd_toc = 1'b0;
  logic xfer_done = 1'b0, seq_ack = 1'b0;
  logic start_pulse, start_kind, exit_req, stop_req, next_is_restart;

  always #2.5 clk = ~clk;

  xfer_start_gate #(.FIFO_DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .thr_we(thr_we),
    .thr_tx_wdata(thr_tx_wdata), .thr_rx_wdata(thr_rx_wdata),
    .tx_level(tx_level), .rx_free(rx_free),
    .cmd_valid(cmd_valid), .cmd_rnw(cmd_rnw), .cmd_hdr(cmd_hdr), .cmd_toc(cmd_toc),
    .xfer_done(xfer_done), .seq_ack(seq_ack),
    .start_pulse(start_pulse), .start_kind(start_kind),
    .exit_req(exit_req), .stop_req(stop_req), .next_is_restart(next_is_restart)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  string cur_req = "R1";

  // Reference model: bus phase as a small integer, thresholds as integers
  // 0 free, 1 running, 2 held, 3 exit asked, 4 exit pending, 5 stop asked, 6 stop pending
  int phase = 0;
  int m_tx_thr = 0, m_rx_thr = 0;
  bit run_hdr = 0, run_toc = 0;
  bit saw_start = 0;
  bit last_kind = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
    end
  endtask

  task automatic step();
    bit ready, e_start, e_kind, e_exit, e_stop, e_hold;
    #1;
    ready = cmd_rnw ? (int'(rx_free) >= m_rx_thr) : (int'(tx_level) >= m_tx_thr);
    e_start = 0; e_kind = 0;
    if (phase == 0 && cmd_valid && ready) e_start = 1;
    if (phase == 2 && cmd_valid && (!cmd_hdr || ready)) begin e_start = 1; e_kind = 1; end
    e_exit = (phase == 3);
    e_stop = (phase == 5);
    e_hold = (phase == 2);
    chk(start_pulse == e_start, cur_req, "start_pulse", start_pulse, e_start);
    if (e_start) chk(start_kind == e_kind, cur_req, "start_kind", start_kind, e_kind);
    chk(exit_req == e_exit, cur_req, "exit_req", exit_req, e_exit);
    chk(stop_req == e_stop, cur_req, "stop_req", stop_req, e_stop);
    chk(next_is_restart == e_hold, cur_req, "next_is_restart", next_is_restart, e_hold);
    saw_start = e_start;
    if (e_start) last_kind = e_kind;
    @(posedge clk);
    if (!rst_n) begin
      phase = 0; m_tx_thr = 0; m_rx_thr = 0;
    end else begin
      if (thr_we) begin m_tx_thr = thr_tx_wdata; m_rx_thr = thr_rx_wdata; end
      case (phase)
        0: if (e_start) begin phase = 1; run_hdr = cmd_hdr; run_toc = cmd_toc; end
        1: if (xfer_done) phase = run_toc ? (run_hdr ? 3 : 5) : 2;
        2: if (cmd_valid) begin
             if (e_start) begin phase = 1; run_hdr = cmd_hdr; run_toc = cmd_toc; end
             else phase = 3;
           end
        3: phase = 4;
        4: if (seq_ack) phase = 5;
        5: phase = 6;
        6: if (seq_ack) phase = 0;
        default: phase = 0;
      endcase
    end
    @(negedge clk);
  endtask

  task automatic steps(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  // Step until the pending command is taken, then withdraw it
  task automatic until_start(input int limit, input string req, input bit exp_kind);
    int k = 0;
    saw_start = 0;
    while (!saw_start && k < limit) begin step(); k++; end
    chk(saw_start, req, "start seen", saw_start, 1);
    if (saw_start) chk(last_kind == exp_kind, req, "condition kind", last_kind, exp_kind);
    cmd_valid = 1'b0;
  endtask

  task automatic finish_xfer();
    xfer_done = 1'b1; step(); xfer_done = 1'b0;
  endtask

  task automatic ack_after(input int wait_cycles);
    steps(wait_cycles);
    seq_ack = 1'b1; step(); seq_ack = 1'b0;
  endtask

  initial begin
    @(negedge clk);
    cur_req = "R1";
    steps(3);
    rst_n = 1'b1;
    steps(2);

    // R4: zero thresholds, empty transmit FIFO, write starts at once
    cur_req = "R4";
    cmd_valid = 1; cmd_rnw = 0; cmd_hdr = 0; cmd_toc = 1; tx_level = 0;
    #1; chk(start_pulse == 1'b1, "R4", "immediate start", start_pulse, 1);
    until_start(1, "R4", 1'b0);
    steps(2);
    cur_req = "R9";
    finish_xfer();
    ack_after(2);
    ack_after(1);
    steps(1);

    // R5 then R2: transmit threshold 5, receive threshold 3
    cur_req = "R5";
    thr_we = 1; thr_tx_wdata = 5; thr_rx_wdata = 3; step(); thr_we = 0;
    cur_req = "R2";
    cmd_valid = 1; cmd_rnw = 0; cmd_hdr = 0; cmd_toc = 0; tx_level = 4;
    steps(4);
    chk(!saw_start, "R2", "held below threshold", saw_start, 0);
    tx_level = 5;
    until_start(2, "R2", 1'b0);
    steps(1);
    cur_req = "R6";
    finish_xfer();
    #1; chk(next_is_restart == 1'b1, "R6", "bus held", next_is_restart, 1);
    steps(1);

    // R7: plain-rate RESTART ignores an empty FIFO
    cur_req = "R7";
    cmd_valid = 1; cmd_rnw = 0; cmd_hdr = 0; cmd_toc = 0; tx_level = 0;
    until_start(1, "R7", 1'b1);
    finish_xfer();

    // R8: double-data-rate read RESTART with threshold met
    cur_req = "R8";
    cmd_valid = 1; cmd_rnw = 1; cmd_hdr = 1; cmd_toc = 0; rx_free = 3;
    until_start(1, "R8", 1'b1);
    finish_xfer();

    // R8: double-data-rate write RESTART below threshold falls back
    cmd_valid = 1; cmd_rnw = 0; cmd_hdr = 1; cmd_toc = 1; tx_level = 2;
    step();
    #1; chk(exit_req == 1'b1, "R8", "exit requested", exit_req, 1);
    cur_req = "R10";
    ack_after(3);
    #1; chk(stop_req == 1'b1, "R8", "stop after exit", stop_req, 1);
    ack_after(2);
    cur_req = "R8";
    steps(3);
    chk(!saw_start, "R8", "waits for threshold", saw_start, 0);
    tx_level = 5;
    until_start(2, "R8", 1'b0);
    cur_req = "R9";
    finish_xfer();
    #1; chk(exit_req == 1'b1, "R9", "hdr close exit", exit_req, 1);
    ack_after(1);
    ack_after(1);

    // R3: read waits for receive free space, boundary one below
    cur_req = "R3";
    cmd_valid = 1; cmd_rnw = 1; cmd_hdr = 0; cmd_toc = 1; rx_free = 2;
    steps(3);
    chk(!saw_start, "R3", "held below threshold", saw_start, 0);
    rx_free = 8;
    until_start(2, "R3", 1'b0);
    cur_req = "R9";
    finish_xfer();
    #1; chk(exit_req == 1'b0 && stop_req == 1'b1, "R9", "plain close stop only", stop_req, 1);
    ack_after(1);
    ack_after(1);

    // R5: full-depth threshold reached exactly
    cur_req = "R5";
    thr_we = 1; thr_tx_wdata = 8; thr_rx_wdata = 0; step(); thr_we = 0;
    cmd_valid = 1; cmd_rnw = 0; cmd_hdr = 0; cmd_toc = 1; tx_level = 7;
    steps(2);
    chk(!saw_start, "R5", "new threshold applied", saw_start, 0);
    tx_level = 8;
    until_start(2, "R5", 1'b0);
    steps(2);

    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule